// File: doc/BRIEF.md
# Cascadable Up/Down Counter with Snapshot Register

This block pairs a small synchronous up/down counter with a holding register that has its own clock, and places a two-way selector in front of a bus-capable output. The counter can be loaded in parallel. It counts up or down when both of its active-low enables are asserted. Its active-low carry output feeds the carry-in enable of the next stage, so several copies chain into a wider counter. The holding register takes a snapshot of the live count on its own clock edge. A select line then decides whether the bus sees the live count or the frozen snapshot.

Two build-time parameters pick the variant. One chooses binary (0 to 15) or decimal (0 to 9) counting. The other chooses a clear that acts at once or a clear that waits for the next counter-clock edge. The three-state output appears as a data word plus an active-high drive-enable flag. Logic around the block turns these into real bus drivers.

Top module: `ud_count_snap`

## Requirements
- R1: While `load_n` is 0, a rising `cnt_clk` edge copies `din` into the counter, whatever the enables and direction are.
- R2: With `load_n` at 1, a rising `cnt_clk` edge steps the counter only when both `enp_n` and `ent_n` are 0. If either is 1, the counter holds its value.
- R3: In binary mode (`BASE = BASE_BIN`), counting up from 15 gives 0 and counting down from 0 gives 15; `up` = 1 means up.
- R4: In decimal mode (`BASE = BASE_DEC`), counting up from 9 or from any larger loaded value gives 0, and counting down from 0 gives 9.
- R5: `rco_n` is 0 exactly when `ent_n` is 0 and the counter is at its terminal value (the maximum when `up` = 1, 0 when `up` = 0). `enp_n` has no effect on it.
- R6: With `CLR_MODE = CLR_ASYNC`, the counter reads 0 as soon as `clr_n` is 0, without waiting for a clock edge.
- R7: With `CLR_MODE = CLR_SYNC`, `clr_n` at 0 zeroes the counter on the next rising `cnt_clk` edge and wins over load and count. Between edges the counter keeps its value.
- R8: A rising `reg_clk` edge copies the current counter value into the snapshot register, with no dependence on `cnt_clk`. The snapshot holds until the next `reg_clk` edge.
- R9: `q` carries the counter value when `sel_reg` is 0 and the snapshot when `sel_reg` is 1.
- R10: `q_en` is 1 when `oe_n` is 0 and 0 when `oe_n` is 1 (0 stands for high impedance on the bus).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cnt_clk | input | 1 | Counter clock, rising edge |
| clr_n | input | 1 | Counter clear, active low |
| load_n | input | 1 | Parallel load request, active low |
| enp_n | input | 1 | Count enable (master), active low |
| ent_n | input | 1 | Count enable (carry-in), active low; also gates `rco_n` |
| up | input | 1 | Direction: 1 up, 0 down |
| din | input | WIDTH | Parallel load value |
| reg_clk | input | 1 | Snapshot register clock, rising edge |
| sel_reg | input | 1 | Output select: 0 counter, 1 snapshot |
| oe_n | input | 1 | Output drive enable, active low |
| q | output | WIDTH | Selected output data |
| q_en | output | 1 | Output drive enable, active high |
| rco_n | output | 1 | Ripple carry out, active low |

## Verification
The bench builds two copies of the block side by side and feeds them the same stimulus. One copy is binary with an immediate clear, and the other is decimal with a clock-synchronous clear. This setup makes the wrap points, the terminal-count carry and the behaviour of a loaded out-of-range value differ between the copies under identical inputs. Dropping the clear between clock edges shows one copy at zero while the other still holds its count. Asserting clear and load together on the synchronous copy checks that clear wins.

// File: rtl/ud_count_pkg.sv
// Package: shared variant selectors for the up/down counter block.
// Assumes: consumers import the enums as parameter types.
package ud_count_pkg;
    typedef enum logic {BASE_BIN = 1'b0, BASE_DEC = 1'b1} count_base_e;
    typedef enum logic {CLR_ASYNC = 1'b0, CLR_SYNC = 1'b1} clr_mode_e;
endpackage

// File: rtl/ud_count_core.sv
// Module: loadable up/down counter with cascade enables and carry out.
// Does: load > count priority; a clear mode picked by parameter, where the
//       synchronous clear outranks load. Wraps at the base-dependent top value.
// Assumes: WIDTH >= 4 when BASE_DEC is chosen.
module ud_count_core
    import ud_count_pkg::*;
#(
    parameter int          WIDTH    = 4,
    parameter count_base_e BASE     = BASE_BIN,
    parameter clr_mode_e   CLR_MODE = CLR_ASYNC
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             enp_n,
    input  logic             ent_n,
    input  logic             up,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] cnt,
    output logic             rco_n
);
    localparam logic [WIDTH-1:0] TOP_VAL =
        (BASE == BASE_DEC) ? WIDTH'(9) : {WIDTH{1'b1}};

    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] step_val;
    logic [WIDTH-1:0] nxt_val;
    logic             at_term;

    // Next value one step away, wrapping at either end of the range.
    always_comb begin
        if (up) begin
            step_val = (cnt_q >= TOP_VAL) ? '0 : cnt_q + 1'b1;
        end else begin
            step_val = (cnt_q == '0) ? TOP_VAL : cnt_q - 1'b1;
        end
    end

    // Load wins over counting; both enables must be low to step.
    always_comb begin
        if (!load_n) begin
            nxt_val = din;
        end else if (!enp_n && !ent_n) begin
            nxt_val = step_val;
        end else begin
            nxt_val = cnt_q;
        end
    end

    generate
        if (CLR_MODE == CLR_ASYNC) begin : g_clr_async
            // Counter state with a clear that acts at once.
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= nxt_val;
                end
            end
        end else begin : g_clr_sync
            // Counter state with a clear sampled on the clock edge.
            always_ff @(posedge clk) begin
                if (!clr_n) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= nxt_val;
                end
            end
        end
    endgenerate

    // Terminal value depends on the current direction.
    always_comb begin
        at_term = up ? (cnt_q == TOP_VAL) : (cnt_q == '0);
    end

    // Carry out is gated only by the carry-in enable.
    always_comb begin
        rco_n = !(!ent_n && at_term);
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/ud_snap_reg.sv
// Module: snapshot register on its own clock.
// Does: captures the counter value on every rising reg_clk edge.
// Assumes: no reset; contents are undefined until the first capture.
module ud_snap_reg #(
    parameter int WIDTH = 4
) (
    input  logic             reg_clk,
    input  logic [WIDTH-1:0] cnt_in,
    output logic [WIDTH-1:0] snap
);
    logic [WIDTH-1:0] snap_q;

    // Capture the live count on the register clock.
    always_ff @(posedge reg_clk) begin
        snap_q <= cnt_in;
    end

    assign snap = snap_q;
endmodule

// File: rtl/ud_out_sel.sv
// Module: output selector and drive-enable for the shared bus.
// Does: picks counter or snapshot; turns the active-low enable into a flag.
// Assumes: bus drivers outside the block honour q_en.
module ud_out_sel #(
    parameter int WIDTH = 4
) (
    input  logic             sel_reg,
    input  logic             oe_n,
    input  logic [WIDTH-1:0] cnt_in,
    input  logic [WIDTH-1:0] snap_in,
    output logic [WIDTH-1:0] q,
    output logic             q_en
);
    // Choose the data source for the bus.
    always_comb begin
        q = sel_reg ? snap_in : cnt_in;
    end

    // Drive flag: high means the bus is driven.
    always_comb begin
        q_en = !oe_n;
    end
endmodule

// File: rtl/ud_count_snap.sv
// Module: top of the cascadable counter with snapshot register and bus mux.
// Does: wires counter, snapshot register and output selector together.
// Assumes: cnt_clk and reg_clk are independent; reg_clk edges are not placed
//          on a counter edge when a clean snapshot is wanted.
module ud_count_snap
    import ud_count_pkg::*;
#(
    parameter int          WIDTH    = 4,
    parameter count_base_e BASE     = BASE_BIN,
    parameter clr_mode_e   CLR_MODE = CLR_ASYNC
) (
    input  logic             cnt_clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             enp_n,
    input  logic             ent_n,
    input  logic             up,
    input  logic [WIDTH-1:0] din,
    input  logic             reg_clk,
    input  logic             sel_reg,
    input  logic             oe_n,
    output logic [WIDTH-1:0] q,
    output logic             q_en,
    output logic             rco_n
);
    logic [WIDTH-1:0] cnt_val;
    logic [WIDTH-1:0] snap_val;

    ud_count_core #(
        .WIDTH(WIDTH), .BASE(BASE), .CLR_MODE(CLR_MODE)
    ) u_core (
        .clk(cnt_clk), .clr_n(clr_n), .load_n(load_n), .enp_n(enp_n),
        .ent_n(ent_n), .up(up), .din(din), .cnt(cnt_val), .rco_n(rco_n)
    );

    ud_snap_reg #(.WIDTH(WIDTH)) u_snap (
        .reg_clk(reg_clk), .cnt_in(cnt_val), .snap(snap_val)
    );

    ud_out_sel #(.WIDTH(WIDTH)) u_sel (
        .sel_reg(sel_reg), .oe_n(oe_n), .cnt_in(cnt_val),
        .snap_in(snap_val), .q(q), .q_en(q_en)
    );
endmodule

// File: rtl/ud_count_snap_chk.sv
// Module: property checker for the counter, bound into every top instance.
// Assumes: clr_n low is the reset for all clocked properties.
module ud_count_snap_chk
    import ud_count_pkg::*;
#(
    parameter int          WIDTH = 4,
    parameter count_base_e BASE  = BASE_BIN
) (
    input logic             cnt_clk,
    input logic             clr_n,
    input logic             load_n,
    input logic             enp_n,
    input logic             ent_n,
    input logic             up,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] cnt,
    input logic             rco_n
);
    localparam logic [WIDTH-1:0] MAX_V =
        (BASE == BASE_DEC) ? WIDTH'(9) : {WIDTH{1'b1}};

    AST_LOAD_WINS: assert property (@(posedge cnt_clk) disable iff (!clr_n)
        !load_n |=> cnt == $past(din)); // R1

    AST_HOLD_IDLE: assert property (@(posedge cnt_clk) disable iff (!clr_n)
        (load_n && (enp_n || ent_n)) |=> $stable(cnt)); // R2

    AST_WRAP_UP: assert property (@(posedge cnt_clk) disable iff (!clr_n)
        (load_n && !enp_n && !ent_n && up && cnt >= MAX_V) |=> cnt == '0); // R3

    AST_WRAP_DOWN: assert property (@(posedge cnt_clk) disable iff (!clr_n)
        (load_n && !enp_n && !ent_n && !up && cnt == '0) |=> cnt == MAX_V); // R4

    AST_CARRY_GATED: assert property (@(posedge cnt_clk) disable iff (!clr_n)
        !rco_n |-> (!ent_n && (cnt == '0 || cnt == MAX_V))); // R5
endmodule

bind ud_count_snap ud_count_snap_chk #(.WIDTH(WIDTH), .BASE(BASE)) u_chk (
    .cnt_clk(cnt_clk), .clr_n(clr_n), .load_n(load_n), .enp_n(enp_n),
    .ent_n(ent_n), .up(up), .din(din), .cnt(cnt_val), .rco_n(rco_n)
);

// File: tb/ud_count_snap_bench.sv
`timescale 1ns/1ps
// Bench: two copies (binary + immediate clear, decimal + synchronous clear)
// driven alike; directed tasks, each checking its own results.
module ud_count_snap_bench;
    import ud_count_pkg::*;

    logic       clk = 1'b0;
    logic       clr_n, load_n, enp_n, ent_n, up, reg_clk, sel_reg, oe_n;
    logic [3:0] din;
    logic [3:0] qa, qb;
    logic       qa_en, qb_en, rcoa_n, rcob_n;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    ud_count_snap #(.WIDTH(4), .BASE(BASE_BIN), .CLR_MODE(CLR_ASYNC)) u_ud_count_snap (
        .cnt_clk(clk), .clr_n(clr_n), .load_n(load_n), .enp_n(enp_n),
        .ent_n(ent_n), .up(up), .din(din), .reg_clk(reg_clk),
        .sel_reg(sel_reg), .oe_n(oe_n), .q(qa), .q_en(qa_en), .rco_n(rcoa_n)
    );

    ud_count_snap #(.WIDTH(4), .BASE(BASE_DEC), .CLR_MODE(CLR_SYNC)) u_ud_count_snap_dec (
        .cnt_clk(clk), .clr_n(clr_n), .load_n(load_n), .enp_n(enp_n),
        .ent_n(ent_n), .up(up), .din(din), .reg_clk(reg_clk),
        .sel_reg(sel_reg), .oe_n(oe_n), .q(qb), .q_en(qb_en), .rco_n(rcob_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Advance to just after the next counter edge.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic load_both(input logic [3:0] v);
        load_n = 1'b0; din = v;
        step();
        load_n = 1'b1;
    endtask

    task automatic t_clear();
        clr_n = 1'b0; load_n = 1'b1; enp_n = 1'b1; ent_n = 1'b1; up = 1'b1;
        din = 4'd0; reg_clk = 1'b0; sel_reg = 1'b0; oe_n = 1'b0;
        #1;
        chk("R6 bin clear before any edge", {4'd0, qa}, 8'd0);
        step();
        chk("R7 dec clear on edge", {4'd0, qb}, 8'd0);
        chk("R10 drive on a", {7'd0, qa_en}, 8'd1);
        clr_n = 1'b1;
    endtask

    task automatic t_load();
        enp_n = 1'b0; ent_n = 1'b0; up = 1'b1;
        load_both(4'd7);
        chk("R1 load over count a", {4'd0, qa}, 8'd7);
        chk("R1 load over count b", {4'd0, qb}, 8'd7);
    endtask

    task automatic t_up();
        step();
        chk("R2 up a 8", {4'd0, qa}, 8'd8);
        chk("R2 up b 8", {4'd0, qb}, 8'd8);
        step();
        chk("R2 up a 9", {4'd0, qa}, 8'd9);
        step();
        chk("R3 bin passes 9", {4'd0, qa}, 8'd10);
        chk("R4 dec wraps 9 to 0", {4'd0, qb}, 8'd0);
    endtask

    task automatic t_down();
        load_both(4'd0);
        up = 1'b0;
        step();
        chk("R3 bin down 0 to 15", {4'd0, qa}, 8'd15);
        chk("R4 dec down 0 to 9", {4'd0, qb}, 8'd9);
        step();
        chk("R2 down a", {4'd0, qa}, 8'd14);
        chk("R2 down b", {4'd0, qb}, 8'd8);
    endtask

    task automatic t_hold();
        enp_n = 1'b1;
        step();
        chk("R2 enp high holds a", {4'd0, qa}, 8'd14);
        chk("R2 enp high holds b", {4'd0, qb}, 8'd8);
        enp_n = 1'b0; ent_n = 1'b1;
        step();
        chk("R2 ent high holds a", {4'd0, qa}, 8'd14);
        chk("R2 ent high holds b", {4'd0, qb}, 8'd8);
        ent_n = 1'b0;
    endtask

    task automatic t_rco();
        enp_n = 1'b1; up = 1'b1;
        load_both(4'd9);
        chk("R5 bin 9 up no carry", {7'd0, rcoa_n}, 8'd1);
        chk("R5 dec 9 up carry", {7'd0, rcob_n}, 8'd0);
        ent_n = 1'b1; #1;
        chk("R5 ent high blocks a", {7'd0, rcoa_n}, 8'd1);
        chk("R5 ent high blocks b", {7'd0, rcob_n}, 8'd1);
        ent_n = 1'b0; up = 1'b0; #1;
        chk("R5 9 down no carry b", {7'd0, rcob_n}, 8'd1);
        load_both(4'd0);
        chk("R5 0 down carry a", {7'd0, rcoa_n}, 8'd0);
        chk("R5 0 down carry b", {7'd0, rcob_n}, 8'd0);
        up = 1'b1;
        load_both(4'd15);
        chk("R5 bin 15 up carry", {7'd0, rcoa_n}, 8'd0);
        chk("R5 dec 15 not terminal", {7'd0, rcob_n}, 8'd1);
        enp_n = 1'b0;
        step();
        chk("R3 bin 15 up to 0", {4'd0, qa}, 8'd0);
        chk("R4 dec 15 up to 0", {4'd0, qb}, 8'd0);
        enp_n = 1'b1;
    endtask

    task automatic t_reg();
        load_both(4'd5);
        reg_clk = 1'b1; #1; reg_clk = 1'b0;
        load_both(4'd3);
        sel_reg = 1'b1; #1;
        chk("R8 R9 snapshot a", {4'd0, qa}, 8'd5);
        chk("R8 R9 snapshot b", {4'd0, qb}, 8'd5);
        sel_reg = 1'b0; #1;
        chk("R9 live count a", {4'd0, qa}, 8'd3);
        chk("R9 live count b", {4'd0, qb}, 8'd3);
        reg_clk = 1'b1; #1; reg_clk = 1'b0;
        sel_reg = 1'b1; #1;
        chk("R8 second capture", {4'd0, qa}, 8'd3);
        sel_reg = 1'b0;
    endtask

    task automatic t_oe();
        oe_n = 1'b1; #1;
        chk("R10 off a", {7'd0, qa_en}, 8'd0);
        chk("R10 off b", {7'd0, qb_en}, 8'd0);
        oe_n = 1'b0; #1;
        chk("R10 on b", {7'd0, qb_en}, 8'd1);
    endtask

    task automatic t_clr_mode();
        load_both(4'd4);
        clr_n = 1'b0; #1;
        chk("R6 async clear between edges", {4'd0, qa}, 8'd0);
        chk("R7 sync clear waits for edge", {4'd0, qb}, 8'd4);
        load_n = 1'b0; din = 4'd6; enp_n = 1'b0;
        step();
        chk("R7 clear over load b", {4'd0, qb}, 8'd0);
        chk("R6 clear held a", {4'd0, qa}, 8'd0);
        clr_n = 1'b1; load_n = 1'b1; enp_n = 1'b1;
    endtask

    initial begin
        t_clear();
        t_load();
        t_up();
        t_down();
        t_hold();
        t_rco();
        t_reg();
        t_oe();
        t_clr_mode();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule